// File: doc/BRIEF.md
# SATA Index/Data Register Window

This block is a slave-side register window. It gives indirect access to the per-device SATA status, control and error registers of up to four device slots. The slots are two ports with two devices each. A simple 32-bit memory-mapped bus reaches a 16-byte window that holds an index register and a data register. Software first writes the index to name a device slot and a register. It then reads or writes the data register, and the block routes that access to the named register.

The backing store holds one status, one control and one error register per slot, each 32 bits wide. The error register follows write-1-to-clear semantics. A dedicated test input lets hardware, or a testbench, set error bits in any slot. Two word offsets of the window are reserved.

Top module: `sata_idx_window`

## Requirements
- R1: While rst_ni is low, and after it is released, every status, control and error register, the index, and rdata_o are zero.
- R2: Word decode uses addr_i[3:2], and addr_i[1:0] is ignored. Word 0 (byte 0x0) is the index and word 1 (byte 0x4) is the data register. A read (req_i=1, we_i=0) loads rdata_o on that clock edge, so the value is visible in the following cycle. rdata_o holds its value until the next read.
- R3: An index write stores wdata_i[15:8] as the slot field and wdata_i[7:0] as the selector field. Reading the index returns {16'h0, slot, selector}.
- R4: The slot number is port × 2 + device, where device 0 is the master and device 1 is the slave. This gives slots 0 to 3.
- R5: Selector 0 names status, 1 names control and 2 names error. A data read returns the register named by the latest index write.
- R6: A data write with selector 0 or 1 replaces the named register with wdata_i.
- R7: A data write with selector 2 clears each error bit whose wdata_i bit is 1. It leaves the other bits unchanged.
- R8: When err_set_valid_i is 1, the bits of err_set_bits_i are set in the error register of slot err_set_slot_i. A slot above 3 is ignored. In the same cycle, a set of a bit wins over a clear of that bit.
- R9: With a slot field above 3 or a selector above 2, data reads return zero and data writes change no register.
- R10: Word offsets 2 and 3 (bytes 0x8 and 0xC) read as zero. Writes to them change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_set_valid_i | input | 1 | Error-set strobe |
| err_set_slot_i | input | 8 | Slot whose error register receives the set |
| err_set_bits_i | input | 32 | Error bits to set |

## Verification
The assertions assume that each bus access lasts exactly one req_i cycle. They also assume that the index stays stable between the data access and the cycle that follows it, because the read-data checks compare against the selected register one cycle later. The stimulus issues one access per task call and always drops req_i in between. It raises err_set_valid_i only in its own cycles, except in the one test of a set and a clear in the same cycle, where the checks that assume no concurrent set stay inactive.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NUM_REGS = 3;

  typedef enum logic [1:0] {
    WIN_INDEX = 2'd0,
    WIN_DATA  = 2'd1,
    WIN_RSV0  = 2'd2,
    WIN_RSV1  = 2'd3
  } win_e;

  localparam int unsigned REG_STATUS  = 0;
  localparam int unsigned REG_CONTROL = 1;
  localparam int unsigned REG_ERROR   = 2;
endpackage

// File: rtl/sidx_index_reg.sv
module sidx_index_reg
  import sidx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned SEL_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              hit_o
);
  localparam int unsigned PAD_W = DATA_W - SLOT_W - SEL_W;

  logic [SLOT_W-1:0] slot_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sel_q  <= '0;
    end else if (wr_i) begin
      slot_q <= wdata_i[SEL_W +: SLOT_W];
      sel_q  <= wdata_i[SEL_W-1:0];
    end
  end

  assign idx_o  = {{PAD_W{1'b0}}, slot_q, sel_q};
  assign slot_o = slot_q;
  assign sel_o  = sel_q;
  assign hit_o  = (slot_q < SLOT_W'(NUM_SLOTS)) && (sel_q < SEL_W'(NUM_REGS));
endmodule

// File: rtl/sidx_reg_bank.sv
module sidx_reg_bank
  import sidx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned SEL_W     = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_i,
  input  logic                                   hit_i,
  input  logic [SLOT_W-1:0]                      slot_i,
  input  logic [SEL_W-1:0]                       sel_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  input  logic                                   err_set_valid_i,
  input  logic [SLOT_W-1:0]                      err_set_slot_i,
  input  logic [DATA_W-1:0]                      err_set_bits_i,
  output logic [NUM_SLOTS-1:0][NUM_REGS-1:0][DATA_W-1:0] regs_o,
  output logic [DATA_W-1:0]                      rd_data_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic              this_slot;
    logic [DATA_W-1:0] status_q, control_q, error_q;
    logic [DATA_W-1:0] err_clr, err_set;

    assign this_slot = wr_i && hit_i && (slot_i == SLOT_W'(g));
    assign err_clr = (this_slot && sel_i == SEL_W'(REG_ERROR)) ? wdata_i : '0;
    assign err_set = (err_set_valid_i && err_set_slot_i == SLOT_W'(g)) ? err_set_bits_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        status_q  <= '0;
        control_q <= '0;
        error_q   <= '0;
      end else begin
        if (this_slot && sel_i == SEL_W'(REG_STATUS))  status_q  <= wdata_i;
        if (this_slot && sel_i == SEL_W'(REG_CONTROL)) control_q <= wdata_i;
        // set has priority over a clear of the same bit
        error_q <= (error_q & ~err_clr) | err_set;
      end
    end

    assign regs_o[g][REG_STATUS]  = status_q;
    assign regs_o[g][REG_CONTROL] = control_q;
    assign regs_o[g][REG_ERROR]   = error_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (hit_i && slot_i == SLOT_W'(s) && sel_i == SEL_W'(r)) rd_data_o = regs_o[s][r];
      end
    end
  end
endmodule

// File: rtl/sata_idx_window.sv
module sata_idx_window
  import sidx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned SEL_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              err_set_valid_i,
  input  logic [SLOT_W-1:0] err_set_slot_i,
  input  logic [DATA_W-1:0] err_set_bits_i
);
  win_e              win;
  logic              idx_wr, dat_wr, rd_en;
  logic [DATA_W-1:0] idx_val, bank_rd, rd_next, rdata_q;
  logic [SLOT_W-1:0] idx_slot;
  logic [SEL_W-1:0]  idx_sel;
  logic              idx_hit;
  logic [NUM_SLOTS-1:0][NUM_REGS-1:0][DATA_W-1:0] bank_regs;

  assign win    = win_e'(addr_i[3:2]);
  assign idx_wr = req_i && we_i && (win == WIN_INDEX);
  assign dat_wr = req_i && we_i && (win == WIN_DATA);
  assign rd_en  = req_i && !we_i;

  sidx_index_reg #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SEL_W(SEL_W)
  ) i_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (idx_wr),
    .wdata_i(wdata_i),
    .idx_o  (idx_val),
    .slot_o (idx_slot),
    .sel_o  (idx_sel),
    .hit_o  (idx_hit)
  );

  sidx_reg_bank #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SEL_W(SEL_W)
  ) i_bank (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (dat_wr),
    .hit_i          (idx_hit),
    .slot_i         (idx_slot),
    .sel_i          (idx_sel),
    .wdata_i        (wdata_i),
    .err_set_valid_i(err_set_valid_i),
    .err_set_slot_i (err_set_slot_i),
    .err_set_bits_i (err_set_bits_i),
    .regs_o         (bank_regs),
    .rd_data_o      (bank_rd)
  );

  always_comb begin
    unique case (win)
      WIN_INDEX: rd_next = idx_val;
      WIN_DATA:  rd_next = bank_rd;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sidx_window_chk.sv
module sidx_window_chk
  import sidx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned SEL_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_set_valid_i,
  input logic [SLOT_W-1:0] err_set_slot_i,
  input logic [DATA_W-1:0] err_set_bits_i,
  input logic [DATA_W-1:0] idx_val,
  input logic [SLOT_W-1:0] idx_slot,
  input logic [SEL_W-1:0]  idx_sel,
  input logic              idx_hit,
  input logic [NUM_SLOTS-1:0][NUM_REGS-1:0][DATA_W-1:0] bank_regs
);
  localparam int unsigned SIW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned RIW = $clog2(NUM_REGS);

  logic rd_idx, rd_dat, rd_rsv, wr_idx, wr_dat, wr_rsv, set_ok;
  assign rd_idx = req_i && !we_i && addr_i[3:2] == 2'd0;
  assign rd_dat = req_i && !we_i && addr_i[3:2] == 2'd1;
  assign rd_rsv = req_i && !we_i && addr_i[3];
  assign wr_idx = req_i && we_i && addr_i[3:2] == 2'd0;
  assign wr_dat = req_i && we_i && addr_i[3:2] == 2'd1;
  assign wr_rsv = req_i && we_i && addr_i[3];
  assign set_ok = err_set_valid_i && err_set_slot_i < SLOT_W'(NUM_SLOTS);

  // R3
  idx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> idx_val == {16'h0, $past(wdata_i[15:0])});

  // R2
  idx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx |=> rdata_o == $past(idx_val));

  // R5
  data_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && idx_hit) |=> rdata_o == $past(bank_regs[idx_slot[SIW-1:0]][idx_sel[RIW-1:0]]));

  // R9
  miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && !idx_hit) |=> rdata_o == '0);

  // R9
  miss_write_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && !idx_hit && !err_set_valid_i) |=> $stable(bank_regs));

  // R10
  rsv_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsv |=> rdata_o == '0);

  // R10
  rsv_write_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rsv && !err_set_valid_i) |=> ($stable(bank_regs) && $stable(idx_val)));

  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ok |=> (bank_regs[$past(err_set_slot_i[SIW-1:0])][REG_ERROR] & $past(err_set_bits_i))
               == $past(err_set_bits_i));

  // R7
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && idx_hit && idx_sel == SEL_W'(REG_ERROR) && !err_set_valid_i)
    |=> (bank_regs[$past(idx_slot[SIW-1:0])][REG_ERROR] & $past(wdata_i)) == '0);
endmodule

bind sata_idx_window sidx_window_chk #(
  .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SEL_W(SEL_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .err_set_valid_i(err_set_valid_i),
  .err_set_slot_i (err_set_slot_i),
  .err_set_bits_i (err_set_bits_i),
  .idx_val        (idx_val),
  .idx_slot       (idx_slot),
  .idx_sel        (idx_sel),
  .idx_hit        (idx_hit),
  .bank_regs      (bank_regs)
);

// File: tb/test_sata_idx_window.sv
module test_sata_idx_window;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_set_valid_i = 1'b0;
  logic [7:0]  err_set_slot_i = '0;
  logic [31:0] err_set_bits_i = '0;

  int checks = 0, errors = 0;
  logic [31:0] m_reg [4][3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sata_idx_window i_sata_idx_window (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    rd = rdata_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus(1'b0, a, 32'h0, v);
  endtask

  task automatic err_set(input logic [7:0] s, input logic [31:0] b);
    err_set_valid_i = 1'b1; err_set_slot_i = s; err_set_bits_i = b;
    @(negedge clk_i);
    err_set_valid_i = 1'b0;
  endtask

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 3; r++) begin
        wr(4'h0, {16'h0, 8'(s), 8'(r)});
        rd(4'h4, v);
        chk($sformatf("%s slot%0d sel%0d", tag, s, r), v, m_reg[s][r]);
      end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 3; r++) m_reg[s][r] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    clear_model();
    repeat (3) @(negedge clk_i);
    chk("R1 rdata in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rdata after reset", rdata_o, 32'h0);
    rd(4'h0, v);
    chk("R1 index after reset", v, 32'h0);
    sweep("R1 regs after reset");

    // R4 slot = port*2 + dev; R6 status/control writes
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++) begin
        int s = p * 2 + d;
        wr(4'h0, {16'h0, 8'(s), 8'd0});
        m_reg[s][0] = 32'hA5A5_0000 | 32'(s * 16 + 1);
        wr(4'h4, m_reg[s][0]);
        wr(4'h0, {16'h0, 8'(s), 8'd1});
        m_reg[s][1] = 32'h3C3C_0000 | 32'(s * 16 + 2);
        wr(4'h4, m_reg[s][1]);
      end
    sweep("R4 R5 R6 write readback");

    // R3 index field packing, upper bits read zero; R2 low address bits ignored
    wr(4'h0, 32'hFFFF_0201);
    rd(4'h0, v);
    chk("R3 index readback", v, 32'h0000_0201);
    rd(4'h3, v);
    chk("R2 index via byte 3", v, 32'h0000_0201);
    rd(4'h6, v);
    chk("R2 data via byte 6", v, m_reg[2][1]);
    wr(4'h1, {16'h0, 8'd3, 8'd0});
    rd(4'h0, v);
    chk("R2 index write via byte 1", v, 32'h0000_0300);
    rd(4'h4, v);
    chk("R5 slot3 status", v, m_reg[3][0]);
    @(negedge clk_i);
    chk("R2 rdata holds", rdata_o, m_reg[3][0]);

    // R8 error set per slot, out-of-range slot ignored
    for (int s = 0; s < 4; s++) begin
      logic [31:0] b = (32'h0F0F_F0F0 >> s) | (32'h1 << (s + 20));
      err_set(8'(s), b);
      m_reg[s][2] |= b;
    end
    err_set(8'd5, 32'hFFFF_FFFF);
    err_set(8'd255, 32'hFFFF_FFFF);
    sweep("R8 error set");

    // R7 write-1-to-clear
    for (int s = 0; s < 4; s++) begin
      logic [31:0] c = 32'h0000_FFFF << (s * 4);
      wr(4'h0, {16'h0, 8'(s), 8'd2});
      wr(4'h4, c);
      m_reg[s][2] &= ~c;
    end
    wr(4'h0, {16'h0, 8'd1, 8'd2});
    wr(4'h4, 32'h0);
    sweep("R7 w1c");

    // R8 set wins over clear in the same cycle
    wr(4'h0, {16'h0, 8'd0, 8'd2});
    err_set_valid_i = 1'b1; err_set_slot_i = 8'd0; err_set_bits_i = 32'h8000_0001;
    wr(4'h4, 32'h8000_0003);
    err_set_valid_i = 1'b0;
    m_reg[0][2] = (m_reg[0][2] & ~32'h8000_0003) | 32'h8000_0001;
    rd(4'h4, v);
    chk("R8 set beats clear", v, m_reg[0][2]);

    // R9 out-of-range index
    begin
      logic [15:0] bad [4] = '{16'h0400, 16'h0003, 16'hFFFF, 16'h00FF};
      for (int i = 0; i < 4; i++) begin
        wr(4'h0, {16'h0, bad[i]});
        rd(4'h4, v);
        chk($sformatf("R9 miss read %h", bad[i]), v, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
      end
    end
    sweep("R9 miss writes ignored");

    // R10 reserved offsets
    wr(4'h0, {16'h0, 8'd2, 8'd1});
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8, v);
    chk("R10 offset 8 reads zero", v, 32'h0);
    rd(4'hC, v);
    chk("R10 offset C reads zero", v, 32'h0);
    rd(4'h0, v);
    chk("R10 index untouched", v, 32'h0000_0201);
    sweep("R10 regs untouched");

    // R1 reset in mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    clear_model();
    chk("R1 rdata after second reset", rdata_o, 32'h0);
    rd(4'h0, v);
    chk("R1 index after second reset", v, 32'h0);
    sweep("R1 regs after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule